// File: doc/BRIEF.md
# Timed Pin-Sequence Link Entry Detector

This block watches a differential pin pair that normally sits in its complementary idle state (P high, N low). It recognises a three-phase timed pattern on that pair and then raises a link flag, which tells the rest of the chip to pass line signals straight through. In the first phase both pins are held high. The length of that phase is measured, checked against fixed limits and stored. The second phase (idle level) and the third phase (both pins low) must each last about as long as the first, within a tolerance. The flag comes up only when the pair is released back to idle after the third phase.

All timing limits are parameters counted in clock cycles: `T1_MIN`, `T1_MAX` and `TOL`. The pins and the enable input pass through a two-flop synchronizer before the sequencer uses them. A phase fails at once if its level is wrong or its upper time bound is reached. After a failure, a new attempt is accepted only once the idle level has been seen again. A low enable stops every attempt and clears the flag. A reset also clears it.

Top module: `link_seq_det`

## Requirements
- R1: After reset, `link_o` is 0 and `phase_o` is 0.
- R2: Phase 1 is entered from idle when P=1,N=1 is sampled. It is accepted if it lasts t1 samples with T1_MIN < t1 < T1_MAX, ending with P=1,N=0. Otherwise the attempt is dropped.
- R3: Phase 2 (P=1,N=0) must last t2 samples with t1-TOL < t2 < t1+TOL and end with P=0,N=0. Otherwise the attempt is dropped.
- R4: Phase 3 (P=0,N=0) must last t3 samples with t1-TOL < t3 < t1+TOL and end with P=1,N=0. Otherwise the attempt is dropped.
- R5: `link_o` rises only on the release to P=1,N=0 after a valid phase 3. It is high at the third rising clock edge after the release is applied at the inputs.
- R6: A phase that reaches its upper bound (t1 = T1_MAX, or t2 or t3 = t1+TOL) is dropped at once, while the level is still held. `phase_o` then returns to 0.
- R7: After a dropped attempt, or after any level other than idle or P=1,N=1 seen in idle, P=1,N=1 starts phase 1 only once P=1,N=0 has been seen first.
- R8: While `en_i` is 0, no sequence is accepted and `link_o` stays 0.
- R9: `link_o` stays high whatever the pins do, until `en_i` goes low (it clears within 3 cycles) or reset.
- R10: `phase_o` encodes 0 = idle or waiting, 1 = phase 1, 2 = phase 2, 3 = phase 3, 4 = link state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| en_i | input | 1 | Enable; low blocks entry and exits the link state |
| p_i | input | 1 | Positive pin level of the pair (asynchronous) |
| n_i | input | 1 | Negative pin level of the pair (asynchronous) |
| link_o | output | 1 | Link state flag |
| phase_o | output | 3 | Current phase code (see R10) |

## Verification
Three nested loops cover the phase lengths. t1 runs from below T1_MIN to above T1_MAX. t2 and t3 each run over offsets of -3 to +3 from t1. Together these hit both strict edges of the fixed window and of the self-referenced window. Directed patterns cover the remaining rules:
- a phase-1 level held far past its limit, which tells an immediate drop apart from one that waits for a level change;
- an entry straight from a both-low level, which shows whether the idle level is required first;
- valid sequences with enable low;
- pin activity while in link state.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_P1   = 3'd1,
    ST_P2   = 3'd2,
    ST_P3   = 3'd3,
    ST_LINK = 3'd4,
    ST_WAIT = 3'd5
  } lsd_state_e;

  // pair level {p, n}
  typedef enum logic [1:0] {
    LV_LO   = 2'b00,
    LV_REV  = 2'b01,
    LV_IDLE = 2'b10,
    LV_HI   = 2'b11
  } lsd_level_e;
endpackage

// File: rtl/lsd_sync.sv
module lsd_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lsd_timer.sv
module lsd_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  // load_i restarts at 1: the sample that opened the phase counts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (load_i) cnt_o <= CW'(1);
    else if (cnt_o != CNT_MAX) cnt_o <= cnt_o + CW'(1);
  end
endmodule

// File: rtl/lsd_fsm.sv
module lsd_fsm
  import lsd_pkg::*;
#(
  parameter int T1_MIN = 4,
  parameter int T1_MAX = 12,
  parameter int TOL    = 2,
  parameter int CW     = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  lsd_level_e    lvl_i,
  input  logic [CW-1:0] cnt_i,
  output logic          load_o,
  output lsd_state_e    st_o
);
  localparam int XW = CW + 1;
  localparam logic [XW-1:0] T1_MIN_X = XW'(T1_MIN);
  localparam logic [XW-1:0] T1_MAX_X = XW'(T1_MAX);
  localparam logic [XW-1:0] TOL_X    = XW'(TOL);

  lsd_state_e    st_q, st_d;
  logic [CW-1:0] t1_q, t1_d;
  logic [XW-1:0] cnt_x, cnt_nx, t1_x;
  logic          win_lo_ok, win_hi_hit;

  assign cnt_x      = {1'b0, cnt_i};
  assign cnt_nx     = cnt_x + XW'(1);
  assign t1_x       = {1'b0, t1_q};
  // t > t1 - TOL, written without subtraction
  assign win_lo_ok  = (cnt_x + TOL_X) > t1_x;
  // next sample would reach t1 + TOL
  assign win_hi_hit = cnt_nx >= (t1_x + TOL_X);

  always_comb begin
    st_d   = st_q;
    t1_d   = t1_q;
    load_o = 1'b0;
    if (!en_i) begin
      st_d = ST_WAIT;
    end else begin
      unique case (st_q)
        ST_WAIT: if (lvl_i == LV_IDLE) st_d = ST_IDLE;
        ST_IDLE: begin
          if (lvl_i == LV_HI) begin
            st_d   = ST_P1;
            load_o = 1'b1;
          end else if (lvl_i != LV_IDLE) begin
            st_d = ST_WAIT;
          end
        end
        ST_P1: begin
          if (lvl_i == LV_HI) begin
            if (cnt_nx >= T1_MAX_X) st_d = ST_WAIT;
          end else if (lvl_i == LV_IDLE && cnt_x > T1_MIN_X) begin
            st_d   = ST_P2;
            t1_d   = cnt_i;
            load_o = 1'b1;
          end else begin
            st_d = ST_WAIT;
          end
        end
        ST_P2: begin
          if (lvl_i == LV_IDLE) begin
            if (win_hi_hit) st_d = ST_WAIT;
          end else if (lvl_i == LV_LO && win_lo_ok) begin
            st_d   = ST_P3;
            load_o = 1'b1;
          end else begin
            st_d = ST_WAIT;
          end
        end
        ST_P3: begin
          if (lvl_i == LV_LO) begin
            if (win_hi_hit) st_d = ST_WAIT;
          end else if (lvl_i == LV_IDLE && win_lo_ok) begin
            st_d = ST_LINK;
          end else begin
            st_d = ST_WAIT;
          end
        end
        ST_LINK: st_d = ST_LINK;
        default: st_d = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      t1_q <= '0;
    end else begin
      st_q <= st_d;
      t1_q <= t1_d;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/link_seq_det.sv
module link_seq_det
  import lsd_pkg::*;
#(
  parameter int T1_MIN = 4,
  parameter int T1_MAX = 12,
  parameter int TOL    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       p_i,
  input  logic       n_i,
  output logic       link_o,
  output logic [2:0] phase_o
);
  localparam int CW = $clog2(T1_MAX + TOL + 2);

  logic [2:0]    raw, syn;
  logic          en_s;
  lsd_level_e    lvl;
  logic [CW-1:0] cnt;
  logic          load;
  lsd_state_e    st;

  assign raw = {en_i, p_i, n_i};

  lsd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign en_s = syn[2];
  assign lvl  = lsd_level_e'(syn[1:0]);

  lsd_timer #(.CW(CW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .cnt_o (cnt)
  );

  lsd_fsm #(.T1_MIN(T1_MIN), .T1_MAX(T1_MAX), .TOL(TOL), .CW(CW)) u_fsm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_s),
    .lvl_i (lvl),
    .cnt_i (cnt),
    .load_o(load),
    .st_o  (st)
  );

  assign link_o  = (st == ST_LINK);
  assign phase_o = (st == ST_WAIT) ? 3'd0 : 3'(st);
endmodule

// File: rtl/lsd_chk.sv
module lsd_chk #(
  parameter int T1_MAX = 12,
  parameter int CW     = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_s,
  input logic          link_o,
  input logic [2:0]    phase_o,
  input logic [CW-1:0] cnt
);
  // R5
  link_from_p3_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_o) |-> $past(phase_o) == 3'd3);

  // R9
  link_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |=> !link_o);

  // R9
  link_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_o && en_s) |=> link_o);

  // R2
  p1_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd1 |-> cnt < CW'(T1_MAX));

  // R3
  p2_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd2 && $past(phase_o) != 3'd2) |-> $past(phase_o) == 3'd1);

  // R8
  no_entry_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_s && !link_o) |=> !link_o);
endmodule

bind link_seq_det lsd_chk #(.T1_MAX(T1_MAX), .CW(CW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_s   (en_s),
  .link_o (link_o),
  .phase_o(phase_o),
  .cnt    (cnt)
);

// File: tb/tb_link_seq_det.sv
module tb_link_seq_det;
  localparam int CLK_PERIOD = 10;
  localparam int T1_MIN = 4;
  localparam int T1_MAX = 12;
  localparam int TOL    = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1;
  logic       p_i = 1'b1;
  logic       n_i = 1'b0;
  logic       link_o;
  logic [2:0] phase_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  link_seq_det #(.T1_MIN(T1_MIN), .T1_MAX(T1_MAX), .TOL(TOL)) dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .p_i    (p_i),
    .n_i    (n_i),
    .link_o (link_o),
    .phase_o(phase_o)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive level {p,n} for k sampling edges; called at a negedge
  task automatic hold(logic [1:0] lv, int k);
    {p_i, n_i} = lv;
    repeat (k) @(negedge clk_i);
  endtask

  task automatic back_to_idle();
    en_i = 1'b0;
    hold(2'b10, 4);
    en_i = 1'b1;
    hold(2'b10, 4);
  endtask

  task automatic run_seq(int t1, int t2, int t3);
    hold(2'b11, t1);
    hold(2'b10, t2);
    hold(2'b00, t3);
    hold(2'b10, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 / R10
    check("R1 link", int'(link_o), 0);
    check("R1 phase", int'(phase_o), 0);
    rst_ni = 1'b1;
    hold(2'b10, 4);

    // R2 R3 R4 R5 sweep
    for (int t1 = 2; t1 <= 14; t1++) begin
      for (int d2 = -3; d2 <= 3; d2++) begin
        for (int d3 = -3; d3 <= 3; d3++) begin
          int t2 = t1 + d2;
          int t3 = t1 + d3;
          bit ok;
          if (t2 < 1 || t3 < 1) continue;
          ok = (t1 > T1_MIN) && (t1 < T1_MAX) &&
               (t2 > t1 - TOL) && (t2 < t1 + TOL) &&
               (t3 > t1 - TOL) && (t3 < t1 + TOL);
          run_seq(t1, t2, t3);
          if (t1 <= T1_MIN || t1 >= T1_MAX)
            check("R2 sweep", int'(link_o), int'(ok));
          else if (t2 <= t1 - TOL || t2 >= t1 + TOL)
            check("R3 sweep", int'(link_o), int'(ok));
          else if (t3 <= t1 - TOL || t3 >= t1 + TOL)
            check("R4 sweep", int'(link_o), int'(ok));
          else
            check("R5 sweep", int'(link_o), int'(ok));
          if (ok) check("R10 link code", int'(phase_o), 4);
          back_to_idle();
          check("R9 exit", int'(link_o), 0);
        end
      end
    end

    // R5 latency: not before the third edge after release
    hold(2'b11, 6); hold(2'b10, 6); hold(2'b00, 6);
    hold(2'b10, 2);
    check("R5 early", int'(link_o), 0);
    hold(2'b10, 1);
    check("R5 on time", int'(link_o), 1);

    // R9 pin activity in link state
    hold(2'b00, 5); hold(2'b11, 7); hold(2'b01, 3); hold(2'b10, 2);
    check("R9 hold", int'(link_o), 1);
    back_to_idle();
    check("R9 exit", int'(link_o), 0);

    // R10 phase codes mid-sequence (3-edge latency)
    hold(2'b11, 3);
    check("R10 p1", int'(phase_o), 1);
    hold(2'b11, 3); hold(2'b10, 3);
    check("R10 p2", int'(phase_o), 2);
    hold(2'b10, 3); hold(2'b00, 3);
    check("R10 p3", int'(phase_o), 3);
    back_to_idle();

    // R6 over-long phase 1 dropped while level held
    hold(2'b11, T1_MAX + 4);
    check("R6 p1 overrun", int'(phase_o), 0);
    hold(2'b10, 4);
    // R6 over-long phase 2
    hold(2'b11, 6); hold(2'b10, 6 + TOL + 4);
    check("R6 p2 overrun", int'(phase_o), 0);
    back_to_idle();

    // R7 both-low in idle, then a valid shape without idle first
    hold(2'b00, 3);
    hold(2'b11, 6); hold(2'b10, 6); hold(2'b00, 6); hold(2'b10, 4);
    check("R7 no restart", int'(link_o), 0);
    // restart after idle works
    run_seq(6, 6, 6);
    check("R7 restart", int'(link_o), 1);
    back_to_idle();

    // R8 enable low blocks entry
    en_i = 1'b0;
    hold(2'b10, 4);
    run_seq(6, 6, 6);
    hold(2'b10, 2);
    check("R8 disabled", int'(link_o), 0);
    en_i = 1'b1;
    hold(2'b10, 4);
    check("R8 no late entry", int'(link_o), 0);

    // R1 reset clears link
    run_seq(7, 7, 7);
    check("R5 pre-reset", int'(link_o), 1);
    rst_ni = 1'b0;
    hold(2'b10, 2);
    check("R1 reset clears", int'(link_o), 0);
    rst_ni = 1'b1;
    hold(2'b10, 3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule